// File: doc/BRIEF.md
# Peripheral Node Common Register File

This block is the shared control space of a node on a small addressed peripheral network. It holds 32 byte-wide locations, 00h to 1Fh. A host reaches them over a plain synchronous register bus made of an address, write data, registered read data, a read strobe and a write strobe. The locations are:

- a status byte whose flags follow per-request set and clear rules,
- fixed identity and version bytes,
- a node address that saturates into a legal range,
- an address register and a pointer register for a serial memory,
- a flag register,
- thirteen pass-through slots for special-function bytes that live outside the block.

Reading the memory-read location starts a one-word fetch over a request/acknowledge port. When the word returns, the block writes it into the node's scratch RAM as two bytes through a byte write port. Locations that hold no register answer a read with twice their own address.

Top module: `pnode_common_regs`

## Requirements
- R1: A read of 08h or of any address from 1Ah to 1Fh returns twice the address, for example 10h for 08h and 3Eh for 1Fh. It changes no register and sets no status flag.
- R2: A write to 03h stores 30 when the value is above 30 and stores 1 when it is below 1. Any other value is stored unchanged, and a read of 03h returns the stored value.
- R3: The bad-request flag is status bit 4. Three things set it: a write to a read-only location (00h, 04h, 08h, 17h to 1Fh), a cycle with both strobes high, and a refused fetch. A rejected request changes nothing. The next valid request clears the flag, and a status read returns the value held before that read.
- R4: The timeout flag is status bit 7. It is set when a fetch sees no acknowledge for TMO_CYCLES cycles; the fetch is then abandoned and mem_req falls. Any request other than a status read clears the flag.
- R5: The status byte holds timeout in bit 7, pending in bit 6, bad-request in bit 4, error in bit 3, tx_full in bit 1 and rx_avail in bit 0. Bits 5 and 2 read 0. Bits 1 and 0 follow their inputs live. The error flag is set by err_set and held until err_clr; when both are high in the same cycle, set wins.
- R6: Reads of 01h and 04h return 00h and 01h. A read of 02h returns 01h when VARIANT is 0 and 02h when VARIANT is 1. Reads of 17h, 18h and 19h return VER_MINOR, VER_MAJOR and VER_SUFFIX. Writes to 01h and 02h are accepted but change nothing.
- R7: A read of 06h while no fetch is active raises mem_req with mem_addr equal to the value in 05h. The acknowledge cycle delivers a word. In the next cycle the block writes its high byte to RAM address ptr, where ptr is the value in 07h. In the cycle after that it writes the low byte to ptr-1, wrapping modulo the RAM size.
- R8: The pending flag, status bit 6, is high from the cycle after a fetch starts until the low byte has been written. A read of 06h while it is high starts no fetch and sets bad-request.
- R9: Location 16h is writable. A read of it returns FFh if bit 3 of the last written value was 1 and 00h otherwise.
- R10: A write to 09h+i, for i from 0 to 12, raises sfr_we[i] alone, in that cycle, with sfr_wdata equal to the write data. A read of 09h+i returns byte i of sfr_rdata.
- R11: bus_rdata takes its new value in the cycle after a read strobe and holds it in every other cycle. Locations 05h, 06h and 07h read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Registered read data |
| tx_full | input | 1 | Transmit buffer full, shown live in status |
| rx_avail | input | 1 | Receive data present, shown live in status |
| err_set | input | 1 | Sets the sticky error flag |
| err_clr | input | 1 | Clears the error flag |
| sfr_rdata | input | 104 | Current values of the 13 special-function bytes |
| sfr_wdata | output | 8 | Data for a special-function byte write |
| sfr_we | output | 13 | One-hot write enable per special-function byte |
| mem_req | output | 1 | Fetch request, high while waiting |
| mem_addr | output | MEM_AW | Serial memory word address |
| mem_ack | input | 1 | Fetch acknowledge, one cycle |
| mem_rdata | input | 16 | Fetched word, valid with mem_ack |
| ram_we | output | 1 | Scratch RAM byte write enable |
| ram_addr | output | RAM_AW | Scratch RAM byte address |
| ram_wdata | output | 8 | Scratch RAM byte data |

## Verification
A corrupted status flag shows in the value returned by the next status read. The R3 and R4 rules also mean it shows through whether a later status read still reports it, so a wrong clear condition is visible two requests later. A wrong fetch state shows at once on mem_req or on a missing or misplaced RAM write one and two cycles after the acknowledge. A wrong clamp, pointer or register value shows on the first read-back of that location. The bench mixes seeded random register traffic with directed cases: clamp edges, pointer wrap at zero, a refused fetch, an expired timeout and error set against clear.

// File: rtl/pnode_regs_pkg.sv
package pnode_regs_pkg;
   localparam int unsigned REG_AW = 5;
   typedef logic [REG_AW-1:0] reg_addr_t;

   localparam reg_addr_t A_STATUS    = 5'h00;
   localparam reg_addr_t A_TYPE_HI   = 5'h01;
   localparam reg_addr_t A_TYPE_LO   = 5'h02;
   localparam reg_addr_t A_NODE      = 5'h03;
   localparam reg_addr_t A_FIXED     = 5'h04;
   localparam reg_addr_t A_MADDR     = 5'h05;
   localparam reg_addr_t A_MREAD     = 5'h06;
   localparam reg_addr_t A_MPTR      = 5'h07;
   localparam reg_addr_t A_FILL0     = 5'h08;
   localparam reg_addr_t A_SFR_FIRST = 5'h09;
   localparam reg_addr_t A_SFR_LAST  = 5'h15;
   localparam reg_addr_t A_FLAG      = 5'h16;
   localparam reg_addr_t A_VMIN      = 5'h17;
   localparam reg_addr_t A_VMAJ      = 5'h18;
   localparam reg_addr_t A_VSUF      = 5'h19;

   localparam int unsigned NSFR = int'(A_SFR_LAST) - int'(A_SFR_FIRST) + 1;

   typedef enum logic [1:0] {
      F_IDLE  = 2'd0,
      F_WAIT  = 2'd1,
      F_WR_HI = 2'd2,
      F_WR_LO = 2'd3
   } fetch_state_t;

   typedef struct packed {
      logic tmo;
      logic pend;
      logic rsv5;
      logic bad;
      logic err;
      logic rsv2;
      logic tx_full;
      logic rx_avail;
   } status_t;
endpackage

// File: rtl/pnode_status_flags.sv
module pnode_status_flags
   import pnode_regs_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    tmo_set,
   input  logic    tmo_clr,
   input  logic    bad_set,
   input  logic    bad_clr,
   input  logic    err_set,
   input  logic    err_clr,
   input  logic    pend,
   input  logic    tx_full,
   input  logic    rx_avail,
   output status_t status
);
   logic tmo_q, bad_q, err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmo_q <= 1'b0;
         bad_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         if (tmo_set)      tmo_q <= 1'b1;
         else if (tmo_clr) tmo_q <= 1'b0;
         if (bad_set)      bad_q <= 1'b1;
         else if (bad_clr) bad_q <= 1'b0;
         if (err_set)      err_q <= 1'b1;
         else if (err_clr) err_q <= 1'b0;
      end
   end

   always_comb begin
      status          = '0;
      status.tmo      = tmo_q;
      status.pend     = pend;
      status.bad      = bad_q;
      status.err      = err_q;
      status.tx_full  = tx_full;
      status.rx_avail = rx_avail;
   end

   // R3
   bad_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_set |=> status.bad);
   // R5
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status.err && !err_clr) |=> status.err);
   // R4
   tmo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status.tmo && !tmo_clr) |=> status.tmo);
endmodule

// File: rtl/pnode_word_fetch.sv
module pnode_word_fetch
   import pnode_regs_pkg::*;
#(
   parameter int unsigned MEM_AW     = 8,
   parameter int unsigned RAM_AW     = 8,
   parameter int unsigned TMO_CYCLES = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [7:0]        src_addr,
   input  logic [7:0]        dst_ptr,
   output logic              busy,
   output logic              tmo_pulse,
   output logic              mem_req,
   output logic [MEM_AW-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [15:0]       mem_rdata,
   output logic              ram_we,
   output logic [RAM_AW-1:0] ram_addr,
   output logic [7:0]        ram_wdata
);
   localparam int unsigned CW = (TMO_CYCLES > 2) ? $clog2(TMO_CYCLES) : 1;
   localparam logic [CW-1:0] CNT_LAST = CW'(TMO_CYCLES - 1);

   fetch_state_t      state_q;
   logic [CW-1:0]     cnt_q;
   logic [MEM_AW-1:0] src_q;
   logic [RAM_AW-1:0] ptr_q;
   logic [15:0]       word_q;
   logic              expire;

   assign expire = (state_q == F_WAIT) && !mem_ack && (cnt_q == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= F_IDLE;
         cnt_q   <= '0;
         src_q   <= '0;
         ptr_q   <= '0;
         word_q  <= '0;
      end else begin
         case (state_q)
            F_IDLE: if (start) begin
               state_q <= F_WAIT;
               cnt_q   <= '0;
               src_q   <= src_addr[MEM_AW-1:0];
               ptr_q   <= dst_ptr[RAM_AW-1:0];
            end
            F_WAIT: begin
               if (mem_ack) begin
                  word_q  <= mem_rdata;
                  state_q <= F_WR_HI;
               end else if (expire) begin
                  state_q <= F_IDLE;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            F_WR_HI: state_q <= F_WR_LO;
            default: state_q <= F_IDLE;
         endcase
      end
   end

   always_comb begin
      busy      = (state_q != F_IDLE);
      tmo_pulse = expire;
      mem_req   = (state_q == F_WAIT);
      mem_addr  = src_q;
      ram_we    = (state_q == F_WR_HI) || (state_q == F_WR_LO);
      ram_addr  = (state_q == F_WR_LO) ? RAM_AW'(ptr_q - 1'b1) : ptr_q;
      ram_wdata = (state_q == F_WR_LO) ? word_q[7:0] : word_q[15:8];
   end

   // R7
   ack_to_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack) |=> (ram_we && ram_addr == $past(ptr_q)
                                && ram_wdata == $past(mem_rdata[15:8])));
   // R7
   lsb_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && state_q == F_WR_HI) |=>
         (ram_we && ram_addr == RAM_AW'($past(ram_addr) - 1'b1)));
   // R4
   tmo_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_pulse |=> (!mem_req && !busy));
   // R8
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (mem_req && busy));
endmodule

// File: rtl/pnode_read_mux.sv
module pnode_read_mux
   import pnode_regs_pkg::*;
#(
   parameter int unsigned VARIANT    = 1,
   parameter logic [7:0]  VER_MINOR  = 8'h01,
   parameter logic [7:0]  VER_MAJOR  = 8'h01,
   parameter logic [7:0]  VER_SUFFIX = 8'h42
) (
   input  reg_addr_t         addr,
   input  status_t           status,
   input  logic [7:0]        node,
   input  logic [7:0]        maddr,
   input  logic [7:0]        mread,
   input  logic [7:0]        mptr,
   input  logic              flag,
   input  logic [NSFR*8-1:0] sfr_rdata,
   output logic [7:0]        rd_val
);
   logic [7:0] type_lo;

   if (VARIANT == 0) begin : g_serial
      assign type_lo = 8'h01;
   end else begin : g_parallel
      assign type_lo = 8'h02;
   end

   always_comb begin
      rd_val = {2'b00, addr, 1'b0};
      case (addr)
         A_STATUS:  rd_val = status;
         A_TYPE_HI: rd_val = 8'h00;
         A_TYPE_LO: rd_val = type_lo;
         A_NODE:    rd_val = node;
         A_FIXED:   rd_val = 8'h01;
         A_MADDR:   rd_val = maddr;
         A_MREAD:   rd_val = mread;
         A_MPTR:    rd_val = mptr;
         A_FLAG:    rd_val = {8{flag}};
         A_VMIN:    rd_val = VER_MINOR;
         A_VMAJ:    rd_val = VER_MAJOR;
         A_VSUF:    rd_val = VER_SUFFIX;
         default: begin
            for (int i = 0; i < NSFR; i++) begin
               if (addr == reg_addr_t'(A_SFR_FIRST + reg_addr_t'(i)))
                  rd_val = sfr_rdata[i*8 +: 8];
            end
         end
      endcase
   end
endmodule

// File: rtl/pnode_common_regs.sv
module pnode_common_regs
   import pnode_regs_pkg::*;
#(
   parameter int unsigned VARIANT    = 1,
   parameter logic [7:0]  VER_MINOR  = 8'h01,
   parameter logic [7:0]  VER_MAJOR  = 8'h01,
   parameter logic [7:0]  VER_SUFFIX = 8'h42,
   parameter int unsigned NODE_MIN   = 1,
   parameter int unsigned NODE_MAX   = 30,
   parameter int unsigned NODE_RST   = 1,
   parameter int unsigned MEM_AW     = 8,
   parameter int unsigned RAM_AW     = 8,
   parameter int unsigned TMO_CYCLES = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [4:0]        bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_rd,
   input  logic              bus_wr,
   output logic [7:0]        bus_rdata,
   input  logic              tx_full,
   input  logic              rx_avail,
   input  logic              err_set,
   input  logic              err_clr,
   input  logic [103:0]      sfr_rdata,
   output logic [7:0]        sfr_wdata,
   output logic [12:0]       sfr_we,
   output logic              mem_req,
   output logic [MEM_AW-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [15:0]       mem_rdata,
   output logic              ram_we,
   output logic [RAM_AW-1:0] ram_addr,
   output logic [7:0]        ram_wdata
);
   localparam logic [7:0] NMIN = 8'(NODE_MIN);
   localparam logic [7:0] NMAX = 8'(NODE_MAX);

   if (NSFR != 13) begin : g_chk_nsfr
      $error("special-function slot count must match the 104-bit port");
   end
   if (MEM_AW < 1 || MEM_AW > 8) begin : g_chk_mem_aw
      $error("MEM_AW must be 1..8");
   end
   if (RAM_AW < 1 || RAM_AW > 8) begin : g_chk_ram_aw
      $error("RAM_AW must be 1..8");
   end
   if (NODE_MIN > NODE_MAX || NODE_MAX > 255) begin : g_chk_node
      $error("node range is malformed");
   end
   if (NODE_RST < NODE_MIN || NODE_RST > NODE_MAX) begin : g_chk_node_rst
      $error("NODE_RST outside node range");
   end
   if (TMO_CYCLES < 2) begin : g_chk_tmo
      $error("TMO_CYCLES must be at least 2");
   end
   if (VARIANT > 1) begin : g_chk_variant
      $error("VARIANT must be 0 or 1");
   end

   function automatic logic [7:0] clamp_node(input logic [7:0] v);
      if (v > NMAX)      return NMAX;
      else if (v < NMIN) return NMIN;
      else               return v;
   endfunction

   function automatic logic is_read_only(input reg_addr_t a);
      return (a == A_STATUS) || (a == A_FIXED) || (a == A_FILL0) || (a >= A_VMIN);
   endfunction

   reg_addr_t  addr;
   logic       rd_req, wr_req, both_req, any_req;
   logic       wr_ok, fetch_busy, fetch_start, fetch_refused, tmo_pulse;
   logic       bad_set, bad_clr, tmo_clr;
   logic [7:0] node_q, maddr_q, mread_q, mptr_q, rd_val, rdata_q;
   logic       flag_q;
   status_t    status;

   assign addr          = bus_addr;
   assign rd_req        = bus_rd && !bus_wr;
   assign wr_req        = bus_wr && !bus_rd;
   assign both_req      = bus_rd && bus_wr;
   assign any_req       = bus_rd || bus_wr;
   assign wr_ok         = wr_req && !is_read_only(addr);
   assign fetch_start   = rd_req && (addr == A_MREAD) && !fetch_busy;
   assign fetch_refused = rd_req && (addr == A_MREAD) && fetch_busy;
   assign bad_set       = both_req || (wr_req && is_read_only(addr)) || fetch_refused;
   assign bad_clr       = any_req && !bad_set;
   assign tmo_clr       = any_req && !(rd_req && addr == A_STATUS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         node_q  <= 8'(NODE_RST);
         maddr_q <= '0;
         mread_q <= '0;
         mptr_q  <= '0;
         flag_q  <= 1'b0;
         rdata_q <= '0;
      end else begin
         if (wr_ok) begin
            case (addr)
               A_NODE:  node_q  <= clamp_node(bus_wdata);
               A_MADDR: maddr_q <= bus_wdata;
               A_MREAD: mread_q <= bus_wdata;
               A_MPTR:  mptr_q  <= bus_wdata;
               A_FLAG:  flag_q  <= bus_wdata[3];
               default: ;
            endcase
         end
         if (rd_req) rdata_q <= rd_val;
      end
   end

   assign bus_rdata = rdata_q;
   assign sfr_wdata = bus_wdata;

   for (genvar g = 0; g < NSFR; g++) begin : g_sfr_we
      assign sfr_we[g] = wr_ok && (addr == reg_addr_t'(A_SFR_FIRST + reg_addr_t'(g)));
   end

   pnode_status_flags i_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .tmo_set  (tmo_pulse),
      .tmo_clr  (tmo_clr),
      .bad_set  (bad_set),
      .bad_clr  (bad_clr),
      .err_set  (err_set),
      .err_clr  (err_clr),
      .pend     (fetch_busy),
      .tx_full  (tx_full),
      .rx_avail (rx_avail),
      .status   (status)
   );

   pnode_word_fetch #(
      .MEM_AW     (MEM_AW),
      .RAM_AW     (RAM_AW),
      .TMO_CYCLES (TMO_CYCLES)
   ) i_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (fetch_start),
      .src_addr  (maddr_q),
      .dst_ptr   (mptr_q),
      .busy      (fetch_busy),
      .tmo_pulse (tmo_pulse),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata),
      .ram_we    (ram_we),
      .ram_addr  (ram_addr),
      .ram_wdata (ram_wdata)
   );

   pnode_read_mux #(
      .VARIANT    (VARIANT),
      .VER_MINOR  (VER_MINOR),
      .VER_MAJOR  (VER_MAJOR),
      .VER_SUFFIX (VER_SUFFIX)
   ) i_rmux (
      .addr      (addr),
      .status    (status),
      .node      (node_q),
      .maddr     (maddr_q),
      .mread     (mread_q),
      .mptr      (mptr_q),
      .flag      (flag_q),
      .sfr_rdata (sfr_rdata),
      .rd_val    (rd_val)
   );

   // R2
   node_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata == bus_rdata) |-> (node_q >= NMIN && node_q <= NMAX));
   // R1
   filler_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && addr == A_FILL0) |=> (bus_rdata == 8'h10));
   // R11
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> $stable(bus_rdata));
   // R10
   sfr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sfr_we));
   // R3
   both_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      both_req |=> ($stable(node_q) && $stable(maddr_q) && $stable(mptr_q)));
endmodule

// File: tb/test_pnode_common_regs.sv
module test_pnode_common_regs;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [4:0]   bus_addr = '0;
   logic [7:0]   bus_wdata = '0;
   logic         bus_rd = 1'b0, bus_wr = 1'b0;
   logic [7:0]   bus_rdata;
   logic         tx_full = 1'b0, rx_avail = 1'b0, err_set = 1'b0, err_clr = 1'b0;
   logic [103:0] sfr_rdata = '0;
   logic [7:0]   sfr_wdata;
   logic [12:0]  sfr_we;
   logic         mem_req;
   logic [7:0]   mem_addr;
   logic         mem_ack = 1'b0;
   logic [15:0]  mem_rdata = '0;
   logic         ram_we;
   logic [7:0]   ram_addr, ram_wdata;
   logic [7:0]   ram [256];

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] rv;

   always #5 clk = ~clk;

   pnode_common_regs #(.TMO_CYCLES(16)) i_pnode_common_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
      .tx_full(tx_full), .rx_avail(rx_avail), .err_set(err_set), .err_clr(err_clr),
      .sfr_rdata(sfr_rdata), .sfr_wdata(sfr_wdata), .sfr_we(sfr_we),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
   );

   always @(posedge clk) if (ram_we) ram[ram_addr] <= ram_wdata;

   function automatic logic [7:0] f_clamp(input logic [7:0] v);
      return (v > 8'd30) ? 8'd30 : ((v < 8'd1) ? 8'd1 : v);
   endfunction

   function automatic logic [7:0] f_fixed(input logic [4:0] a);
      case (a)
         5'h01: return 8'h00;
         5'h02: return 8'h02;
         5'h04: return 8'h01;
         5'h17: return 8'h01;
         5'h18: return 8'h01;
         5'h19: return 8'h42;
         default: return {2'b00, a, 1'b0};
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [4:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
      @(posedge clk);
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic pulse_err(input logic s, input logic c);
      @(negedge clk);
      err_set = s; err_clr = c;
      @(posedge clk);
      @(negedge clk);
      err_set = 1'b0; err_clr = 1'b0;
   endtask

   task automatic ack(input logic [15:0] w);
      @(negedge clk);
      mem_ack = 1'b1; mem_rdata = w;
      @(posedge clk);
      @(negedge clk);
      mem_ack = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] seed;
      seed = $urandom(32'd20240);
      for (int i = 0; i < 13; i++) sfr_rdata[i*8 +: 8] = 8'($urandom);
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      chk("R11 reset rdata", 32'(bus_rdata), 32'h0);
      chk("R7 reset mem_req", 32'(mem_req), 32'h0);
      rd(5'h00, rv); chk("R5 reset status", 32'(rv), 32'h00);
      rd(5'h03, rv); chk("R2 reset node", 32'(rv), 32'd1);

      // R6 identity and version bytes
      foreach (f_fixed_list[k]) begin end
      rd(5'h01, rv); chk("R6 type hi", 32'(rv), 32'h00);
      rd(5'h02, rv); chk("R6 type lo", 32'(rv), 32'h02);
      rd(5'h04, rv); chk("R6 fixed 04", 32'(rv), 32'h01);
      rd(5'h17, rv); chk("R6 minor", 32'(rv), 32'h01);
      rd(5'h18, rv); chk("R6 major", 32'(rv), 32'h01);
      rd(5'h19, rv); chk("R6 suffix", 32'(rv), 32'h42);
      wr(5'h01, 8'h77); wr(5'h02, 8'h55);
      rd(5'h01, rv); chk("R6 type hi after write", 32'(rv), 32'h00);
      rd(5'h02, rv); chk("R6 type lo after write", 32'(rv), 32'h02);
      rd(5'h00, rv); chk("R6 type writes not bad", 32'(rv), 32'h00);

      // R1 filler locations
      rd(5'h08, rv); chk("R1 filler 08", 32'(rv), 32'h10);
      for (int a = 5'h1A; a <= 5'h1F; a++) begin
         rd(5'(a), rv); chk("R1 filler", 32'(rv), 32'(2 * a));
      end
      rd(5'h00, rv); chk("R1 no side effect", 32'(rv), 32'h00);

      // R2 clamp edges
      wr(5'h03, 8'd0);   rd(5'h03, rv); chk("R2 zero", 32'(rv), 32'd1);
      wr(5'h03, 8'd30);  rd(5'h03, rv); chk("R2 thirty", 32'(rv), 32'd30);
      wr(5'h03, 8'd31);  rd(5'h03, rv); chk("R2 thirty-one", 32'(rv), 32'd30);
      wr(5'h03, 8'd255); rd(5'h03, rv); chk("R2 max byte", 32'(rv), 32'd30);
      wr(5'h03, 8'd7);   rd(5'h03, rv); chk("R2 mid", 32'(rv), 32'd7);

      // R3 bad request paths
      wr(5'h19, 8'h00);
      rd(5'h00, rv); chk("R3 ro write sets bad", 32'(rv), 32'h10);
      rd(5'h00, rv); chk("R3 status read clears bad", 32'(rv), 32'h00);
      rd(5'h19, rv); chk("R3 ro write ignored", 32'(rv), 32'h42);
      @(negedge clk);
      bus_addr = 5'h03; bus_wdata = 8'd12; bus_rd = 1'b1; bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_rd = 1'b0; bus_wr = 1'b0;
      rd(5'h00, rv); chk("R3 both strobes bad", 32'(rv), 32'h10);
      rd(5'h03, rv); chk("R3 both strobes no write", 32'(rv), 32'd7);

      // R5 error and live bits
      pulse_err(1'b1, 1'b0);
      rd(5'h00, rv); chk("R5 err set", 32'(rv), 32'h08);
      rd(5'h00, rv); chk("R5 err sticky", 32'(rv), 32'h08);
      pulse_err(1'b0, 1'b1);
      rd(5'h00, rv); chk("R5 err cleared", 32'(rv), 32'h00);
      pulse_err(1'b1, 1'b1);
      @(negedge clk) begin tx_full = 1'b1; rx_avail = 1'b1; end
      rd(5'h00, rv); chk("R5 set wins and live bits", 32'(rv), 32'h0B);
      pulse_err(1'b0, 1'b1);
      @(negedge clk) begin tx_full = 1'b0; rx_avail = 1'b0; end

      // R11 read-back and hold
      wr(5'h06, 8'h3C);
      rd(5'h06, rv);
      chk("R11 reg06 readback", 32'(rv), 32'h3C);
      // that read started a fetch; finish it from pointer 0 (wrap case)
      ack(16'h1234);
      repeat (3) @(negedge clk);
      chk("R7 wrap msb", 32'(ram[8'h00]), 32'h12);
      chk("R7 wrap lsb", 32'(ram[8'hFF]), 32'h34);
      wr(5'h05, 8'h5A); wr(5'h07, 8'h20);
      chk("R11 rdata holds over writes", 32'(bus_rdata), 32'h3C);
      rd(5'h05, rv); chk("R11 reg05", 32'(rv), 32'h5A);
      rd(5'h07, rv); chk("R11 reg07", 32'(rv), 32'h20);

      // R7/R8 fetch
      rd(5'h06, rv);
      chk("R7 mem_req", 32'(mem_req), 32'h1);
      chk("R7 mem_addr", 32'(mem_addr), 32'h5A);
      rd(5'h00, rv); chk("R8 pending", 32'(rv), 32'h40);
      wr(5'h05, 8'h11);
      rd(5'h06, rv);
      chk("R8 refused keeps addr", 32'(mem_addr), 32'h5A);
      rd(5'h00, rv); chk("R8 refused sets bad", 32'(rv), 32'h50);
      rd(5'h00, rv); chk("R8 still pending", 32'(rv), 32'h40);
      ack(16'hBEEF);
      chk("R7 msb write cycle", 32'({ram_we, ram_addr, ram_wdata}), 32'h120BE);
      @(negedge clk);
      chk("R7 lsb write cycle", 32'({ram_we, ram_addr, ram_wdata}), 32'h11FEF);
      @(negedge clk);
      chk("R7 stored msb", 32'(ram[8'h20]), 32'hBE);
      chk("R7 stored lsb", 32'(ram[8'h1F]), 32'hEF);
      rd(5'h00, rv); chk("R8 pending cleared", 32'(rv), 32'h00);

      // R4 timeout
      rd(5'h06, rv);
      repeat (20) @(negedge clk);
      chk("R4 request dropped", 32'(mem_req), 32'h0);
      rd(5'h00, rv); chk("R4 timeout set", 32'(rv), 32'h80);
      rd(5'h00, rv); chk("R4 status read keeps", 32'(rv), 32'h80);
      rd(5'h03, rv);
      rd(5'h00, rv); chk("R4 other request clears", 32'(rv), 32'h00);

      // R9 flag register
      wr(5'h16, 8'h08); rd(5'h16, rv); chk("R9 flag set", 32'(rv), 32'hFF);
      wr(5'h16, 8'hF7); rd(5'h16, rv); chk("R9 flag clear", 32'(rv), 32'h00);

      // seeded random mix
      for (int it = 0; it < 300; it++) begin
         int kind;
         logic [7:0] v;
         kind = int'($urandom_range(0, 3));
         v = 8'($urandom);
         if (kind == 0) begin
            wr(5'h03, v); rd(5'h03, rv); chk("R2 random clamp", 32'(rv), 32'(f_clamp(v)));
         end else if (kind == 1) begin
            int s;
            s = int'($urandom_range(0, 12));
            @(negedge clk);
            bus_addr = 5'(9 + s); bus_wdata = v; bus_wr = 1'b1;
            #1;
            chk("R10 sfr we", 32'({sfr_we, sfr_wdata}), 32'({13'(1 << s), v}));
            @(posedge clk);
            @(negedge clk);
            bus_wr = 1'b0;
            #1;
            chk("R10 sfr we drops", 32'(sfr_we), 32'h0);
            rd(5'(9 + s), rv); chk("R10 sfr read", 32'(rv), 32'(sfr_rdata[s*8 +: 8]));
         end else if (kind == 2) begin
            logic [4:0] a;
            a = ($urandom_range(0, 1) == 0) ? 5'h05 : 5'h07;
            wr(a, v); rd(a, rv); chk("R11 random readback", 32'(rv), 32'(v));
         end else begin
            logic [4:0] a;
            case ($urandom_range(0, 5))
               0: a = 5'h08;
               1: a = 5'h01;
               2: a = 5'h02;
               3: a = 5'h04;
               4: a = 5'(5'h17 + $urandom_range(0, 2));
               default: a = 5'(5'h1A + $urandom_range(0, 5));
            endcase
            rd(a, rv); chk("R1 R6 random fixed read", 32'(rv), 32'(f_fixed(a)));
         end
      end
      rd(5'h00, rv); chk("R3 random traffic left no flag", 32'(rv), 32'h00);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   int f_fixed_list [1];
endmodule